// File: doc/BRIEF.md
# ASCII Hex Record Memory Loader

The loader takes a stream of ASCII characters, one per accepted valid/ready transfer, that carries a memory image written as hexadecimal text records. Each record opens with a semicolon. Two hex characters give the number of data bytes, four give the load address, and two more follow for each data byte. The record closes with four hex characters holding a 16-bit additive checksum. The loader turns every data byte into a single write on a simple memory port. The first byte goes to the load address and each later byte goes to the next address up.

A record whose length is zero ends the file. In that record, four hex characters hold the number of data records the file should contain, and the usual checksum follows them. The loader keeps a count of the data records that arrived with a correct checksum. At end of file it raises `done`, and it raises `count_mismatch` as well if its count differs from the count in the file. Checksum errors and format errors are sticky flags. Text between records is treated as comment and skipped.

The parser is a state machine with these states:
- `ST_HUNT` looks for a record mark.
- `ST_LEN` takes the length.
- `ST_ADDR` takes the load address.
- `ST_DATA` takes the data bytes.
- `ST_CSUM` takes the checksum of a data record.
- `ST_EOFCNT` takes the record count of the end-of-file record.
- `ST_EOFSUM` takes the checksum of the end-of-file record.
- `ST_DONE` absorbs every character until reset.

The transitions are:
- HUNT→LEN on a mark.
- LEN→ADDR on a non-zero length.
- LEN→EOFCNT on a zero length.
- ADDR→DATA after the fourth address character.
- DATA→CSUM after the last data byte.
- CSUM→HUNT after the fourth checksum character.
- EOFCNT→EOFSUM after four characters.
- EOFSUM→DONE after four characters.
- Any field state→HUNT on a non-hex character or an over-long length.

Top module: `hexrec_loader`

## Requirements
- R1: In `ST_HUNT`, characters other than the mark 0x3B are accepted and cause no write and no flag change.
- R2: The length byte (high nibble first) must be 0 to 24. A larger value sets the sticky `fmt_err`, ends the record with no write, and returns the parser to hunting.
- R3: The load address is read high byte first. Data byte i of a record is written to (load address + i) modulo 65536, so writes wrap from 0xFFFF to 0x0000.
- R4: Hex digits are 0-9, A-F and a-f, and lowercase letters decode the same as uppercase. Any other character inside a record, including a mark, sets the sticky `fmt_err`, ends the record, and returns the parser to hunting.
- R5: The checksum is the 16-bit sum of the length byte, both address bytes and every data byte, sent as four hex characters with the most significant nibble first. On a mismatch, `cksum_err` is set and stays set, and the record is not counted as good. Writes already issued for that record remain.
- R6: Characters after a record's checksum are skipped until the next mark, and the next record then decodes normally.
- R7: The end-of-file record has length 0, then a 16-bit record count in four hex characters, then a checksum that covers the length byte and both count bytes. Its last character raises `done`. In the same cycle, `count_mismatch` rises if the count differs from the number of good data records; otherwise it stays low. A bad checksum here also sets `cksum_err`.
- R8: Once `done` is high, every character is accepted and ignored: no write and no flag change until reset.
- R9: Each decoded data byte produces exactly one write. `mem_we` rises in the cycle after the second hex character of the byte is accepted, and `mem_addr` and `mem_data` hold steady until a cycle with `mem_ack` high. While a write is pending, `in_ready` is low.
- R10: A synchronous active-high reset gives `in_ready`=1, `mem_we`=0 and all status flags 0, and returns the parser to hunting with its counts cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted when high with in_valid |
| mem_we | output | 1 | Write request, held until acknowledged |
| mem_addr | output | 16 | Write address |
| mem_data | output | 8 | Write data |
| mem_ack | input | 1 | Write accepted this cycle when mem_we is high |
| done | output | 1 | End-of-file record processed (sticky) |
| cksum_err | output | 1 | A record checksum failed (sticky) |
| fmt_err | output | 1 | Length out of range or bad character (sticky) |
| count_mismatch | output | 1 | File record count differed from good records |

## Verification
A data write held back by a withheld acknowledge can overlap with the arrival of the next record text. This happens to the last byte of a record, whose write is still pending while the first checksum character is already presented. The bench provokes the overlap by acknowledging only one cycle in three during several records, including a record of 24 bytes and one that wraps the address. It judges the result two ways. Every completed write must match the next entry in its expected queue. The checksum verdict and good-record count must come out the same as with an always-ready memory, which the end-of-file count comparison confirms.

// File: rtl/hexldr_pkg.sv
package hexldr_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_ADDR,
        ST_DATA,
        ST_CSUM,
        ST_EOFCNT,
        ST_EOFSUM,
        ST_DONE
    } ldr_state_t;

    localparam logic [7:0] MARK_CHAR = 8'h3B;

endpackage

// File: rtl/hexldr_nibble.sv
module hexldr_nibble (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    logic is_digit;
    logic is_upper;
    logic is_lower;

    always_comb begin
        is_digit = (ch >= 8'h30) && (ch <= 8'h39);
        is_upper = (ch >= 8'h41) && (ch <= 8'h46);
        is_lower = (ch >= 8'h61) && (ch <= 8'h66);
        is_hex   = is_digit || is_upper || is_lower;
        nib      = is_digit ? ch[3:0] : (ch[3:0] + 4'd9);
    end

    always_comb begin
        if (is_digit) a_r4_digit_value: assert (nib == ch[3:0]);
    end
endmodule

// File: rtl/hexldr_parser.sv
module hexldr_parser
    import hexldr_pkg::*;
#(
    parameter int MAX_LEN = 24,
    parameter int CNT_W   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [7:0]  ch,
    output logic        wr_fire,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        done,
    output logic        cksum_err,
    output logic        fmt_err,
    output logic        count_mismatch
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    ldr_state_t       state_q, state_d;
    logic [1:0]       nib_q;
    logic [15:0]      acc_q;
    logic [15:0]      sum_q;
    logic [15:0]      addr_q;
    logic [15:0]      file_cnt_q;
    logic [CNT_W-1:0] good_q;
    logic [LEN_W-1:0] left_q;
    logic             done_q, cks_q, fmt_q, mis_q;

    logic        is_hex;
    logic [3:0]  nib;
    logic        in_rec, bad_char, hex_take, byte_done, word_done, len_bad;
    logic [7:0]  byte_val;
    logic [15:0] word_val;

    hexldr_nibble u_nib (
        .ch     (ch),
        .is_hex (is_hex),
        .nib    (nib)
    );

    always_comb begin
        in_rec    = (state_q != ST_HUNT) && (state_q != ST_DONE);
        hex_take  = take && in_rec && is_hex;
        bad_char  = take && in_rec && !is_hex;
        byte_done = hex_take && nib_q[0];
        word_done = hex_take && (nib_q == 2'd3);
        byte_val  = {acc_q[3:0], nib};
        word_val  = {acc_q[11:0], nib};
        len_bad   = byte_val > 8'(MAX_LEN);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (take && ch == MARK_CHAR) state_d = ST_LEN;
            ST_LEN: begin
                if (bad_char) state_d = ST_HUNT;
                else if (byte_done) begin
                    if (len_bad)              state_d = ST_HUNT;
                    else if (byte_val == 8'd0) state_d = ST_EOFCNT;
                    else                      state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (bad_char)       state_d = ST_HUNT;
                else if (word_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bad_char) state_d = ST_HUNT;
                else if (byte_done && left_q == LEN_W'(1)) state_d = ST_CSUM;
            end
            ST_CSUM: begin
                if (bad_char || word_done) state_d = ST_HUNT;
            end
            ST_EOFCNT: begin
                if (bad_char)       state_d = ST_HUNT;
                else if (word_done) state_d = ST_EOFSUM;
            end
            ST_EOFSUM: begin
                if (bad_char)       state_d = ST_HUNT;
                else if (word_done) state_d = ST_DONE;
            end
            ST_DONE:   state_d = ST_DONE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q      <= '0;
            acc_q      <= '0;
            sum_q      <= '0;
            addr_q     <= '0;
            file_cnt_q <= '0;
            good_q     <= '0;
            left_q     <= '0;
            done_q     <= 1'b0;
            cks_q      <= 1'b0;
            fmt_q      <= 1'b0;
            mis_q      <= 1'b0;
        end else begin
            if (take && state_q == ST_HUNT && ch == MARK_CHAR) begin
                nib_q <= '0;
                acc_q <= '0;
                sum_q <= '0;
            end
            if (hex_take) begin
                acc_q <= {acc_q[11:0], nib};
                nib_q <= nib_q + 2'd1;
            end
            if (bad_char) fmt_q <= 1'b1;
            unique case (state_q)
                ST_LEN: if (byte_done) begin
                    sum_q  <= {8'h00, byte_val};
                    left_q <= byte_val[LEN_W-1:0];
                    nib_q  <= '0;
                    if (len_bad) fmt_q <= 1'b1;
                end
                ST_ADDR: begin
                    if (byte_done) sum_q <= sum_q + {8'h00, byte_val};
                    if (word_done) begin
                        addr_q <= word_val;
                        nib_q  <= '0;
                    end
                end
                ST_DATA: if (byte_done) begin
                    addr_q <= addr_q + 16'd1;
                    sum_q  <= sum_q + {8'h00, byte_val};
                    left_q <= left_q - LEN_W'(1);
                    nib_q  <= '0;
                end
                ST_CSUM: if (word_done) begin
                    if (word_val == sum_q) good_q <= good_q + CNT_W'(1);
                    else                   cks_q  <= 1'b1;
                end
                ST_EOFCNT: begin
                    if (byte_done) sum_q <= sum_q + {8'h00, byte_val};
                    if (word_done) begin
                        file_cnt_q <= word_val;
                        nib_q      <= '0;
                    end
                end
                ST_EOFSUM: if (word_done) begin
                    if (word_val != sum_q) cks_q <= 1'b1;
                    done_q <= 1'b1;
                    mis_q  <= (CNT_W'(file_cnt_q) != good_q);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_fire        = (state_q == ST_DATA) && byte_done;
        wr_addr        = addr_q;
        wr_data        = byte_val;
        done           = done_q;
        cksum_err      = cks_q;
        fmt_err        = fmt_q;
        count_mismatch = mis_q;
    end

    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (left_q != '0 && left_q <= LEN_W'(MAX_LEN)));
    a_r4_fmt_sticky: assert property (@(posedge clk) disable iff (rst)
        fmt_q |=> fmt_q);
    a_r5_cks_sticky: assert property (@(posedge clk) disable iff (rst)
        cks_q |=> cks_q);
    a_r7_mis_with_done: assert property (@(posedge clk) disable iff (rst)
        mis_q |-> done_q);
    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (done_q && state_q == ST_DONE && !wr_fire));
endmodule

// File: rtl/hexldr_wrport.sv
module hexldr_wrport #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mem_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else if (fire) begin
            mem_we   <= 1'b1;
            mem_addr <= addr_in;
            mem_data <= data_in;
        end else if (mem_we && mem_ack) begin
            mem_we   <= 1'b0;
        end
    end

    assign busy = mem_we;

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_data)));
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
    parameter int MAX_LEN = 24,
    parameter int CNT_W   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    output logic        in_ready,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_data,
    input  logic        mem_ack,
    output logic        done,
    output logic        cksum_err,
    output logic        fmt_err,
    output logic        count_mismatch
);
    logic        take;
    logic        wr_fire;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_busy;

    assign in_ready = !wr_busy;
    assign take     = in_valid && in_ready;

    hexldr_parser #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_parser (
        .clk            (clk),
        .rst            (rst),
        .take           (take),
        .ch             (in_char),
        .wr_fire        (wr_fire),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .done           (done),
        .cksum_err      (cksum_err),
        .fmt_err        (fmt_err),
        .count_mismatch (count_mismatch)
    );

    hexldr_wrport #(.ADDR_W(16), .DATA_W(8)) u_wrport (
        .clk      (clk),
        .rst      (rst),
        .fire     (wr_fire),
        .addr_in  (wr_addr),
        .data_in  (wr_data),
        .mem_ack  (mem_ack),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .busy     (wr_busy)
    );

    a_r9_no_fire_while_busy: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> !wr_busy);
    a_r9_we_after_fire: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> mem_we);
endmodule

// File: tb/test_hexrec_loader.sv
module test_hexrec_loader;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_ack = 1'b0;
    logic        done, cksum_err, fmt_err, count_mismatch;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_mode = 0;
    bit mon_on = 0;
    int wq[$];
    bit exp_done, exp_cks, exp_fmt, exp_mis;
    int exp_good;

    hexrec_loader i_hexrec_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack), .done(done),
        .cksum_err(cksum_err), .fmt_err(fmt_err), .count_mismatch(count_mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // reference comparison every cycle, away from the active edge
    always @(negedge clk) begin
        mem_ack = (ack_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (mon_on) begin
            chk(fmt_err == exp_fmt, "R2 R4 fmt_err", fmt_err, exp_fmt);
            chk(cksum_err == exp_cks, "R5 cksum_err", cksum_err, exp_cks);
            chk(done == exp_done, "R7 done", done, exp_done);
            chk(count_mismatch == exp_mis, "R7 count_mismatch", count_mismatch, exp_mis);
            chk(in_ready == !mem_we, "R9 ready while pending", in_ready, !mem_we);
            if (mem_we && mem_ack) begin
                if (wq.size() == 0) begin
                    chk(0, "R9 unexpected write", {mem_addr, mem_data}, 0);
                end else begin
                    int e;
                    e = wq.pop_front();
                    chk({mem_addr, mem_data} == e[23:0], "R3 R9 write", {mem_addr, mem_data}, e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mon_on = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wq.delete();
        exp_done = 0; exp_cks = 0; exp_fmt = 0; exp_mis = 0; exp_good = 0;
        chk(in_ready == 1'b1 && mem_we == 1'b0, "R10 reset port state", {in_ready, mem_we}, 2'b10);
        chk({done, cksum_err, fmt_err, count_mismatch} == 4'b0, "R10 reset flags",
            {done, cksum_err, fmt_err, count_mismatch}, 0);
        mon_on = 1;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = s[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
        end
    endtask

    function automatic string hx(input int v, input int digits, input bit lower);
        if (digits == 2) return lower ? $sformatf("%02x", v & 8'hFF) : $sformatf("%02X", v & 8'hFF);
        return lower ? $sformatf("%04x", v & 16'hFFFF) : $sformatf("%04X", v & 16'hFFFF);
    endfunction

    task automatic data_rec(input int addr, input int n, input int seed, input bit bad, input bit lower);
        string s;
        int sum;
        s = {";", hx(n, 2, lower), hx(addr, 4, lower)};
        sum = n + ((addr >> 8) & 8'hFF) + (addr & 8'hFF);
        for (int i = 0; i < n; i++) begin
            int d;
            d = (seed + i * 37) & 8'hFF;
            sum += d;
            s = {s, hx(d, 2, lower)};
            wq.push_back((((addr + i) & 16'hFFFF) << 8) | d);
        end
        if (bad) sum = sum ^ 1;
        s = {s, hx(sum, 4, lower)};
        send_str(s);
        if (bad) exp_cks = 1; else exp_good++;
    endtask

    task automatic eof_rec(input int cnt, input bit bad);
        int sum;
        sum = ((cnt >> 8) & 8'hFF) + (cnt & 8'hFF);
        if (bad) sum = sum ^ 2;
        send_str({";00", hx(cnt, 4, 0), hx(sum, 4, 0)});
        exp_done = 1;
        exp_mis  = (cnt != exp_good);
        if (bad) exp_cks = 1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        do_reset();

        // R1: junk before any mark
        send_str("xyz 12 AB\n");
        settle();
        chk(wq.size() == 0 && fmt_err == 0, "R1 junk ignored", fmt_err, 0);

        data_rec(16'h1000, 3, 8'h11, 0, 0);
        send_str(" load block one\n");
        data_rec(16'h20A0, 4, 8'hC3, 0, 1);
        settle();
        chk(wq.size() == 0, "R6 record after comment written", wq.size(), 0);
        chk(cksum_err == 0, "R4 lowercase checksum accepted", cksum_err, 0);

        ack_mode = 1;
        data_rec(16'hFFFE, 3, 8'h5A, 0, 0);
        data_rec(16'h3000, 2, 8'h77, 1, 0);
        data_rec(16'h4000, 24, 8'h02, 0, 0);
        settle();
        chk(wq.size() == 0, "R3 wrap and 24-byte writes done", wq.size(), 0);
        chk(cksum_err == 1, "R5 bad checksum flagged", cksum_err, 1);
        ack_mode = 0;

        eof_rec(4, 0);
        settle();
        chk(done == 1 && count_mismatch == 0, "R7 count matches", {done, count_mismatch}, 2'b10);

        // R8: text after done is ignored
        send_str(";0150000100AA;zz");
        settle();
        chk(mem_we == 0 && in_ready == 1 && fmt_err == 0, "R8 ignored after done",
            {mem_we, in_ready, fmt_err}, 3'b010);

        // second file: format errors and count mismatch
        do_reset();
        data_rec(16'h0100, 1, 8'h40, 0, 0);
        send_str(";19");
        exp_fmt = 1;
        send_str("00001122\n");
        settle();
        chk(fmt_err == 1 && wq.size() == 0, "R2 length 25 rejected", fmt_err, 1);
        send_str(";0210G");
        send_str("0011\n");
        data_rec(16'h0200, 2, 8'h90, 0, 1);
        settle();
        chk(wq.size() == 0 && cksum_err == 0, "R4 recovery after bad char", cksum_err, 0);
        eof_rec(5, 0);
        settle();
        chk(count_mismatch == 1 && done == 1, "R7 count differs", {done, count_mismatch}, 2'b11);

        // third file: empty image with corrupt end record
        do_reset();
        eof_rec(0, 1);
        settle();
        chk(done == 1 && cksum_err == 1 && count_mismatch == 0, "R7 R5 bad end checksum",
            {done, cksum_err, count_mismatch}, 3'b110);

        mon_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule